// File: doc/BRIEF.md
# Genlock Sync Offset Generator

This block rebuilds the horizontal and vertical sync pulses of an output raster, locked to a reference HSYNC and VSYNC pair and shifted later by a programmable amount. The horizontal shift is counted in pixel clocks and the vertical shift in lines. Both shifts only delay. An advance is obtained by programming the line length (or frame height) minus the desired advance, so that the pulse wraps into the previous line or frame.

A reference HSYNC rising edge restarts a pixel counter that wraps at the programmed clocks-per-line value. A rising reference VSYNC level seen at such an edge restarts a line counter that wraps at the programmed lines-per-frame value. The output HSYNC is a single-clock pulse. The output VSYNC is a level that covers the output line whose index equals the vertical offset. Offsets and raster sizes are captured into shadow registers only at a frame start, and out-of-range offsets are clamped and flagged.

There is a fixed two-clock input latency, so software subtracts 2 from the wanted horizontal delay.

Top module: `genlock_sync_offset`

## Requirements
- R1: After reset `out_hsync`, `out_vsync` and `cfg_err` are 0, and no output pulse appears before the first reference HSYNC rising edge.
- R2: For an effective horizontal offset H, `out_hsync` is high for exactly one clock, H+2 clock edges after the edge that first samples `ref_hsync` high. H = 0 gives the minimum delay of 2 clocks.
- R3: The pixel counter wraps at the clocks-per-line value, so any H up to clocks-per-line minus 1 is valid. This includes values whose pulse lands after the next reference edge, which gives an advance: H = clocks-per-line minus a.
- R4: A frame starts at a reference HSYNC rising edge whose co-sampled `ref_vsync` is 1 while it was 0 at the previous such edge. A VSYNC held over several lines starts only one frame. Lines are numbered from 0 at the frame start.
- R5: `out_vsync` changes only on the edge where `out_hsync` goes high. It is 1 from the output pulse of line V (the effective vertical offset) until the next output pulse, and 0 for every other line.
- R6: A vertical advance of a lines is made with V = lines-per-frame minus a, which places `out_vsync` on that line of the current frame.
- R7: `cfg_err` is 1 one clock after the horizontal offset is at least clocks-per-line or the vertical offset is at least lines-per-frame. It is 0 one clock after both offsets are in range.
- R8: An out-of-range offset is clamped to its limit minus 1: horizontal to clocks-per-line minus 1, vertical to lines-per-frame minus 1.
- R9: Offsets and raster sizes written in the middle of a frame have no effect until the next frame start. Before the first frame start they are taken at every reference HSYNC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_hsync | input | 1 | Reference horizontal sync, active high |
| ref_vsync | input | 1 | Reference vertical sync, active high |
| cfg_h_offset | input | PIX_W (12) | Horizontal delay in pixel clocks |
| cfg_v_offset | input | LINE_W (11) | Vertical delay in lines |
| cfg_clks_per_line | input | PIX_W (12) | Output line length in pixel clocks |
| cfg_lines_per_frame | input | LINE_W (11) | Output frame height in lines |
| out_hsync | output | 1 | Delayed horizontal sync, one-clock pulse |
| out_vsync | output | 1 | Delayed vertical sync, one output line long |
| cfg_err | output | 1 | Offset out of range |

## Verification
The pulse for the last part of a line and the restart caused by the next reference edge can fall in the same clock. At a frame boundary, the shadow reload and the line counter restart land there as well. Horizontal offsets of 29 and 31 on a 32-clock line provoke this, with back-to-back frames whose offsets differ. Each output pulse is judged by its exact clock position against a queue of predicted pulses, and by the `out_vsync` level it carries, which exposes a pulse taken from the wrong line or the wrong shadow value.

// File: rtl/gso_pkg.sv
package gso_pkg;
  localparam int unsigned PIX_W_DEF  = 12;
  localparam int unsigned LINE_W_DEF = 11;

  // one cycle view of the registered reference syncs
  typedef struct packed {
    logic h_rise;   // reference HSYNC rising edge (registered domain)
    logic v_level;  // reference VSYNC sampled with the same edge
  } ref_evt_t;
endpackage

// File: rtl/gso_sync_in.sv
module gso_sync_in
  import gso_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ref_hsync,
  input  logic     ref_vsync,
  output ref_evt_t evt
);
  logic hs_q, hs_qq, vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q  <= 1'b0;
      hs_qq <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      hs_q  <= ref_hsync;
      hs_qq <= hs_q;
      vs_q  <= ref_vsync;
    end
  end

  assign evt.h_rise  = hs_q & ~hs_qq;
  assign evt.v_level = vs_q;
endmodule

// File: rtl/gso_offset_clamp.sv
module gso_offset_clamp #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] req,
  input  logic [W-1:0] limit,
  output logic [W-1:0] eff,
  output logic         over
);
  always_comb begin
    over = (req >= limit);
    if (limit == '0)
      eff = '0;
    else if (over)
      eff = limit - 1'b1;
    else
      eff = req;
  end
endmodule

// File: rtl/gso_wrap_cnt.sv
module gso_wrap_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count
);
  logic at_end;

  assign at_end = (limit == '0) || (count >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (restart)
      count <= '0;
    else if (adv)
      count <= at_end ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/genlock_sync_offset.sv
module genlock_sync_offset
  import gso_pkg::*;
#(
  parameter int unsigned PIX_W  = PIX_W_DEF,
  parameter int unsigned LINE_W = LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_hsync,
  input  logic              ref_vsync,
  input  logic [PIX_W-1:0]  cfg_h_offset,
  input  logic [LINE_W-1:0] cfg_v_offset,
  input  logic [PIX_W-1:0]  cfg_clks_per_line,
  input  logic [LINE_W-1:0] cfg_lines_per_frame,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic              cfg_err
);
  ref_evt_t          evt;
  logic [PIX_W-1:0]  h_req_eff;
  logic [LINE_W-1:0] v_req_eff;
  logic              h_over, v_over;

  // frame shadow
  logic [PIX_W-1:0]  h_eff, cpl_act;
  logic [LINE_W-1:0] v_eff, lpf_act;

  logic              h_locked, v_locked, vs_last;
  logic              new_frame, load_cfg, fire;
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;

  gso_sync_in u_sync (
    .clk       (clk),
    .rst       (rst),
    .ref_hsync (ref_hsync),
    .ref_vsync (ref_vsync),
    .evt       (evt)
  );

  gso_offset_clamp #(.W(PIX_W)) u_clamp_h (
    .req   (cfg_h_offset),
    .limit (cfg_clks_per_line),
    .eff   (h_req_eff),
    .over  (h_over)
  );

  gso_offset_clamp #(.W(LINE_W)) u_clamp_v (
    .req   (cfg_v_offset),
    .limit (cfg_lines_per_frame),
    .eff   (v_req_eff),
    .over  (v_over)
  );

  assign new_frame = evt.h_rise & evt.v_level & ~vs_last;
  assign load_cfg  = evt.h_rise & (new_frame | ~v_locked);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_eff    <= '0;
      v_eff    <= '0;
      cpl_act  <= '0;
      lpf_act  <= '0;
      h_locked <= 1'b0;
      v_locked <= 1'b0;
      vs_last  <= 1'b0;
    end else begin
      if (load_cfg) begin
        h_eff   <= h_req_eff;
        v_eff   <= v_req_eff;
        cpl_act <= cfg_clks_per_line;
        lpf_act <= cfg_lines_per_frame;
      end
      if (evt.h_rise) begin
        h_locked <= 1'b1;
        vs_last  <= evt.v_level;
      end
      if (new_frame)
        v_locked <= 1'b1;
    end
  end

  gso_wrap_cnt #(.W(PIX_W)) u_pix_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (evt.h_rise),
    .adv     (1'b1),
    .limit   (cpl_act),
    .count   (pix_cnt)
  );

  gso_wrap_cnt #(.W(LINE_W)) u_line_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (new_frame),
    .adv     (evt.h_rise),
    .limit   (lpf_act),
    .count   (line_cnt)
  );

  assign fire = h_locked & (pix_cnt == h_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      out_hsync <= fire;
      if (fire)
        out_vsync <= v_locked & (line_cnt == v_eff);
      cfg_err <= h_over | v_over;
    end
  end
endmodule

// File: rtl/gso_checker.sv
module gso_checker #(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned LINE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              out_hsync,
  input logic              out_vsync,
  input logic              cfg_err,
  input logic [PIX_W-1:0]  cfg_h_offset,
  input logic [LINE_W-1:0] cfg_v_offset,
  input logic [PIX_W-1:0]  cfg_clks_per_line,
  input logic [LINE_W-1:0] cfg_lines_per_frame,
  input logic [PIX_W-1:0]  h_eff,
  input logic [LINE_W-1:0] v_eff,
  input logic [PIX_W-1:0]  cpl_act,
  input logic [LINE_W-1:0] lpf_act,
  input logic              h_locked
);
  // R1
  lock_before_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_hsync) |-> $past(h_locked));

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (out_hsync && cpl_act > 1) |=> !out_hsync);

  // R5
  vs_moves_with_hs_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_vsync) |-> out_hsync);

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_h_offset >= cfg_clks_per_line) || (cfg_v_offset >= cfg_lines_per_frame)) |=> cfg_err);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_h_offset < cfg_clks_per_line) && (cfg_v_offset < cfg_lines_per_frame)) |=> !cfg_err);

  // R8
  h_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (cpl_act != '0) |-> (h_eff < cpl_act));

  // R8
  v_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (lpf_act != '0) |-> (v_eff < lpf_act));
endmodule

bind genlock_sync_offset gso_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk                 (clk),
  .rst                 (rst),
  .out_hsync           (out_hsync),
  .out_vsync           (out_vsync),
  .cfg_err             (cfg_err),
  .cfg_h_offset        (cfg_h_offset),
  .cfg_v_offset        (cfg_v_offset),
  .cfg_clks_per_line   (cfg_clks_per_line),
  .cfg_lines_per_frame (cfg_lines_per_frame),
  .h_eff               (h_eff),
  .v_eff               (v_eff),
  .cpl_act             (cpl_act),
  .lpf_act             (lpf_act),
  .h_locked            (h_locked)
);

// File: tb/genlock_sync_offset_test.sv
module genlock_sync_offset_test;
  localparam int PW = 12;
  localparam int LW = 11;
  localparam int CPL = 32;
  localparam int LPF = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_hsync = 1'b0;
  logic          ref_vsync = 1'b0;
  logic [PW-1:0] cfg_h_offset = '0;
  logic [LW-1:0] cfg_v_offset = '0;
  logic [PW-1:0] cfg_clks_per_line = PW'(CPL);
  logic [LW-1:0] cfg_lines_per_frame = LW'(LPF);
  logic          out_hsync, out_vsync, cfg_err;

  genlock_sync_offset #(.PIX_W(PW), .LINE_W(LW)) uut (
    .clk                 (clk),
    .rst                 (rst),
    .ref_hsync           (ref_hsync),
    .ref_vsync           (ref_vsync),
    .cfg_h_offset        (cfg_h_offset),
    .cfg_v_offset        (cfg_v_offset),
    .cfg_clks_per_line   (cfg_clks_per_line),
    .cfg_lines_per_frame (cfg_lines_per_frame),
    .out_hsync           (out_hsync),
    .out_vsync           (out_vsync),
    .cfg_err             (cfg_err)
  );

  always #5 clk = ~clk;

  typedef struct {
    longint cyc;
    bit     vs;
    string  tag;
  } exp_t;

  exp_t   q[$];
  exp_t   e;
  int     compared = 0;
  int     mismatched = 0;
  longint cyc = 0;
  bit     mon_en = 1'b0;
  bit     done = 1'b0;
  int     m_h = 0;
  int     m_v = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clampv(int r, int l);
    if (l == 0) return 0;
    return (r >= l) ? l - 1 : r;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: one reference line of CPL clocks, expected pulse pushed to the scoreboard
  task automatic drive_line(int L, string tag);
    @(negedge clk);
    if (L == 0) begin
      m_h = clampv(int'(cfg_h_offset), int'(cfg_clks_per_line));
      m_v = clampv(int'(cfg_v_offset), int'(cfg_lines_per_frame));
    end
    ref_hsync = 1'b1;
    ref_vsync = (L < 2);   // R4: held over two lines
    q.push_back('{cyc + 3 + m_h, (L == m_v), tag});
    repeat (4) @(negedge clk);
    ref_hsync = 1'b0;
    repeat (CPL - 5) @(negedge clk);
  endtask

  task automatic drive_frame(string tag);
    for (int l = 0; l < LPF; l++) drive_line(l, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_en && out_hsync) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 R2", "unexpected out_hsync at cycle", cyc, -1);
      end else begin
        e = q.pop_front();
        check(cyc == e.cyc, e.tag, "out_hsync cycle", cyc, e.cyc);
        check(out_vsync == e.vs, {e.tag, " R4 R5"}, "out_vsync level", longint'(out_vsync), longint'(e.vs));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_hsync == 1'b0, "R1", "out_hsync after reset", longint'(out_hsync), 0);
    check(out_vsync == 1'b0, "R1", "out_vsync after reset", longint'(out_vsync), 0);
    check(cfg_err == 1'b0, "R1", "cfg_err after reset", longint'(cfg_err), 0);
    mon_en = 1'b1;
    repeat (40) @(negedge clk);   // R1: no pulse without reference

    // R2 minimum latency
    drive_frame("R2 lat0");
    drive_frame("R2 lat0");

    // R2 R3 mid-range
    cfg_h_offset = PW'(10);
    cfg_v_offset = LW'(3);
    drive_frame("R2 R3 mid");
    drive_frame("R2 R3 mid");

    // R3 R6 advance by wrap: 3 clocks and 2 lines
    cfg_h_offset = PW'(CPL - 3);
    cfg_v_offset = LW'(LPF - 2);
    @(negedge clk);
    check(cfg_err == 1'b0, "R7", "cfg_err in range", longint'(cfg_err), 0);
    drive_frame("R3 R6 adv");
    drive_frame("R3 R6 adv");

    // R7 R8 out of range
    cfg_h_offset = PW'(40);
    @(negedge clk);
    check(cfg_err == 1'b1, "R7", "cfg_err h over", longint'(cfg_err), 1);
    cfg_v_offset = LW'(9);
    drive_frame("R8 clamp");
    drive_frame("R8 clamp");
    cfg_h_offset = PW'(12);
    cfg_v_offset = LW'(2);
    @(negedge clk);
    check(cfg_err == 1'b0, "R7", "cfg_err cleared", longint'(cfg_err), 0);

    // R9 mid-frame change
    for (int l = 0; l < LPF; l++) begin
      if (l == 4) begin
        cfg_h_offset = PW'(5);
        cfg_v_offset = LW'(1);
      end
      drive_line(l, "R9 hold");
    end
    drive_frame("R9 apply");

    repeat (5) @(negedge clk);
    mon_en = 1'b0;
    check(q.size() == 0, "R2", "missing pulses", longint'(q.size()), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule